// File: doc/BRIEF.md
# Scan Chain Routing Switch

This block is a combinational routing fabric that sits between one test access master and eight on-board scan chains. Two masters can reach the board: a local header and a remote controller that arrives over a differential cable. A source select input picks which of the two owns the chains. The other master sees a constant high on its data return.

A selection vector marks which chains take part. In chained mode every marked chain is linked in series in ascending index order. The master's data input enters the lowest marked chain, and each chain's data output feeds the next marked chain. The last chain's output returns to the active master. In single mode only the lowest marked chain is connected. Chains 0 to 5 are in the 2.5 V domain and chains 6 and 7 are in the 3.3 V domain. Each domain has its own port group.

Chains that are not connected are parked, with clock low, mode select high, reset released and data input high. When nothing is connected, the master's data input loops straight back to its data output. No input is registered, so the selection must only change while the test clock is idle.

Top module: `jtag_chain_switch`

## Requirements
- R1: With src_rem_i = 1 the remote master's tck, tms, trst_n and tdi drive the chains; with src_rem_i = 0 the header master's do.
- R2: The data output of the master that is not selected by src_rem_i is held at 1.
- R3: Every connected chain receives the active master's tck, tms and trst_n unchanged.
- R4: Every chain that is not connected receives tck = 0, tms = 1, trst_n = 1 and tdi = 1.
- R5: Bit i of chain_sel_i marks chain i. Chains 0..5 are lv port bits 0..5 and chains 6..7 are hv port bits 0..1. Connected chains are linked in ascending index order: the lowest takes the master's tdi, and each later one takes the tdo of the previous connected chain.
- R6: The tdo of the highest connected chain is returned on the active master's tdo output.
- R7: When no chain is connected, the active master's tdo equals its own tdi.
- R8: With single_i = 1 only the lowest-index marked chain is connected, and all other marked chains are parked as in R4. With single_i = 0 all marked chains are connected.
- R9: Outputs follow any input change without a clock edge; the block holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hdr_tck_i | input | 1 | Header master test clock |
| hdr_tms_i | input | 1 | Header master mode select |
| hdr_tdi_i | input | 1 | Header master data in |
| hdr_trst_ni | input | 1 | Header master test reset, active low |
| hdr_tdo_o | output | 1 | Data return to header master |
| rem_tck_i | input | 1 | Remote master test clock |
| rem_tms_i | input | 1 | Remote master mode select |
| rem_tdi_i | input | 1 | Remote master data in |
| rem_trst_ni | input | 1 | Remote master test reset, active low |
| rem_tdo_o | output | 1 | Data return to remote master |
| src_rem_i | input | 1 | 1 selects remote master, 0 selects header |
| single_i | input | 1 | 1 connects only the lowest marked chain |
| chain_sel_i | input | 8 | Chain selection vector, bit i marks chain i |
| lv_tck_o | output | 6 | 2.5 V chain test clocks |
| lv_tms_o | output | 6 | 2.5 V chain mode selects |
| lv_tdi_o | output | 6 | 2.5 V chain data inputs |
| lv_trst_no | output | 6 | 2.5 V chain test resets, active low |
| lv_tdo_i | input | 6 | 2.5 V chain data outputs |
| hv_tck_o | output | 2 | 3.3 V chain test clocks |
| hv_tms_o | output | 2 | 3.3 V chain mode selects |
| hv_tdi_o | output | 2 | 3.3 V chain data inputs |
| hv_trst_no | output | 2 | 3.3 V chain test resets, active low |
| hv_tdo_i | input | 2 | 3.3 V chain data outputs |

## Verification
Directed patterns cover the edge cases. An empty selection shows the loopback. A full selection shows the eight-deep series order. A selection of only the 3.3 V chains shows the domain mapping. A sparse selection in single mode separates the lowest-bit pick from a full chain. Several thousand random input vectors then mix both masters, both modes and random chain outputs. Each chain's tdo is driven with an independent value, so a wrong link order or a wrong return path shows up as a data mismatch. Some vectors change the inputs between clock edges and check them after a short delay, which would expose any hidden register.

// File: rtl/jtag_sw_pkg.sv
package jtag_sw_pkg;
  typedef struct packed {
    logic tck;
    logic tms;
    logic trst_n;
    logic tdi;
  } jtag_drv_t;

  localparam jtag_drv_t PARK_DRV = '{tck: 1'b0, tms: 1'b1, trst_n: 1'b1, tdi: 1'b1};
endpackage

// File: rtl/jtag_sel_mask.sv
module jtag_sel_mask #(
  parameter int N = 8
) (
  input  logic [N-1:0] sel_i,
  input  logic         single_i,
  output logic [N-1:0] act_o
);
  logic [N-1:0] lowest;

  // isolate lowest set bit
  assign lowest = sel_i & (~sel_i + N'(1));
  assign act_o  = single_i ? lowest : sel_i;
endmodule

// File: rtl/jtag_src_mux.sv
module jtag_src_mux
  import jtag_sw_pkg::*;
(
  input  logic      src_rem_i,
  input  jtag_drv_t hdr_i,
  input  jtag_drv_t rem_i,
  input  logic      ret_tdo_i,
  output jtag_drv_t mst_o,
  output logic      hdr_tdo_o,
  output logic      rem_tdo_o
);
  assign mst_o     = src_rem_i ? rem_i : hdr_i;
  assign hdr_tdo_o = src_rem_i ? 1'b1 : ret_tdo_i;
  assign rem_tdo_o = src_rem_i ? ret_tdo_i : 1'b1;
endmodule

// File: rtl/jtag_chain_cell.sv
module jtag_chain_cell
  import jtag_sw_pkg::*;
(
  input  logic      act_i,
  input  jtag_drv_t mst_i,
  input  logic      rip_i,
  input  logic      tdo_i,
  output jtag_drv_t drv_o,
  output logic      rip_o
);
  always_comb begin
    if (act_i) begin
      drv_o     = mst_i;
      drv_o.tdi = rip_i;
    end else begin
      drv_o     = PARK_DRV;
    end
  end

  // bypass unconnected chain in the ripple
  assign rip_o = act_i ? tdo_i : rip_i;
endmodule

// File: rtl/jtag_chain_switch.sv
module jtag_chain_switch
  import jtag_sw_pkg::*;
#(
  parameter int N_LV = 6,
  parameter int N_HV = 2,
  localparam int N   = N_LV + N_HV
) (
  input  logic            hdr_tck_i,
  input  logic            hdr_tms_i,
  input  logic            hdr_tdi_i,
  input  logic            hdr_trst_ni,
  output logic            hdr_tdo_o,
  input  logic            rem_tck_i,
  input  logic            rem_tms_i,
  input  logic            rem_tdi_i,
  input  logic            rem_trst_ni,
  output logic            rem_tdo_o,
  input  logic            src_rem_i,
  input  logic            single_i,
  input  logic [N-1:0]    chain_sel_i,
  output logic [N_LV-1:0] lv_tck_o,
  output logic [N_LV-1:0] lv_tms_o,
  output logic [N_LV-1:0] lv_tdi_o,
  output logic [N_LV-1:0] lv_trst_no,
  input  logic [N_LV-1:0] lv_tdo_i,
  output logic [N_HV-1:0] hv_tck_o,
  output logic [N_HV-1:0] hv_tms_o,
  output logic [N_HV-1:0] hv_tdi_o,
  output logic [N_HV-1:0] hv_trst_no,
  input  logic [N_HV-1:0] hv_tdo_i
);
  jtag_drv_t    hdr_drv, rem_drv, mst;
  logic [N-1:0] act;
  logic [N:0]   rip;
  logic [N-1:0] ch_tdo, ch_tck, ch_tms, ch_tdi, ch_trst_n;

  assign hdr_drv = '{tck: hdr_tck_i, tms: hdr_tms_i, trst_n: hdr_trst_ni, tdi: hdr_tdi_i};
  assign rem_drv = '{tck: rem_tck_i, tms: rem_tms_i, trst_n: rem_trst_ni, tdi: rem_tdi_i};
  assign ch_tdo  = {hv_tdo_i, lv_tdo_i};

  jtag_sel_mask #(.N(N)) u_mask (
    .sel_i   (chain_sel_i),
    .single_i(single_i),
    .act_o   (act)
  );

  jtag_src_mux u_src (
    .src_rem_i(src_rem_i),
    .hdr_i    (hdr_drv),
    .rem_i    (rem_drv),
    .ret_tdo_i(rip[N]),
    .mst_o    (mst),
    .hdr_tdo_o(hdr_tdo_o),
    .rem_tdo_o(rem_tdo_o)
  );

  assign rip[0] = mst.tdi;

  for (genvar i = 0; i < N; i++) begin : g_chain
    jtag_drv_t drv;
    jtag_chain_cell u_cell (
      .act_i(act[i]),
      .mst_i(mst),
      .rip_i(rip[i]),
      .tdo_i(ch_tdo[i]),
      .drv_o(drv),
      .rip_o(rip[i+1])
    );
    assign ch_tck[i]    = drv.tck;
    assign ch_tms[i]    = drv.tms;
    assign ch_tdi[i]    = drv.tdi;
    assign ch_trst_n[i] = drv.trst_n;

    always_comb begin
      if (!chain_sel_i[i]) begin
        // R4
        unsel_parked_chk: assert (ch_tck[i] == 1'b0 && ch_tms[i] == 1'b1 && ch_trst_n[i] == 1'b1);
      end
    end
  end

  assign lv_tck_o   = ch_tck[N_LV-1:0];
  assign lv_tms_o   = ch_tms[N_LV-1:0];
  assign lv_tdi_o   = ch_tdi[N_LV-1:0];
  assign lv_trst_no = ch_trst_n[N_LV-1:0];
  assign hv_tck_o   = ch_tck[N-1:N_LV];
  assign hv_tms_o   = ch_tms[N-1:N_LV];
  assign hv_tdi_o   = ch_tdi[N-1:N_LV];
  assign hv_trst_no = ch_trst_n[N-1:N_LV];

  always_comb begin
    // R8
    single_onehot_chk: assert (!single_i || $onehot0(act));
    // R8
    act_subset_chk: assert ((act & ~chain_sel_i) == '0);
    // R2
    idle_master_high_chk: assert ((src_rem_i ? hdr_tdo_o : rem_tdo_o) == 1'b1);
    if (chain_sel_i == '0) begin
      // R7
      empty_loop_chk: assert ((src_rem_i ? rem_tdo_o : hdr_tdo_o) == (src_rem_i ? rem_tdi_i : hdr_tdi_i));
    end
  end
endmodule

// File: tb/tb_jtag_chain_switch.sv
module tb_jtag_chain_switch;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic hdr_tck, hdr_tms, hdr_tdi, hdr_trst_n, hdr_tdo;
  logic rem_tck, rem_tms, rem_tdi, rem_trst_n, rem_tdo;
  logic src_rem, single;
  logic [7:0] sel;
  logic [5:0] lv_tck, lv_tms, lv_tdi, lv_trst_n, lv_tdo;
  logic [1:0] hv_tck, hv_tms, hv_tdi, hv_trst_n, hv_tdo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  jtag_chain_switch dut (
    .hdr_tck_i(hdr_tck), .hdr_tms_i(hdr_tms), .hdr_tdi_i(hdr_tdi), .hdr_trst_ni(hdr_trst_n),
    .hdr_tdo_o(hdr_tdo),
    .rem_tck_i(rem_tck), .rem_tms_i(rem_tms), .rem_tdi_i(rem_tdi), .rem_trst_ni(rem_trst_n),
    .rem_tdo_o(rem_tdo),
    .src_rem_i(src_rem), .single_i(single), .chain_sel_i(sel),
    .lv_tck_o(lv_tck), .lv_tms_o(lv_tms), .lv_tdi_o(lv_tdi), .lv_trst_no(lv_trst_n),
    .lv_tdo_i(lv_tdo),
    .hv_tck_o(hv_tck), .hv_tms_o(hv_tms), .hv_tdi_o(hv_tdi), .hv_trst_no(hv_trst_n),
    .hv_tdo_i(hv_tdo)
  );

  task automatic check_bit(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  // behavioural reference: walk a queue of connected chains
  task automatic compare(string pre);
    int q[$];
    bit inq[8];
    logic m_tck, m_tms, m_trst, m_tdi, back;
    logic [7:0] tdo_all, g_tck, g_tms, g_tdi, g_trst;
    logic [7:0] e_tck, e_tms, e_tdi, e_trst;
    string rq;
    m_tck  = src_rem ? rem_tck : hdr_tck;
    m_tms  = src_rem ? rem_tms : hdr_tms;
    m_trst = src_rem ? rem_trst_n : hdr_trst_n;
    m_tdi  = src_rem ? rem_tdi : hdr_tdi;
    tdo_all = {hv_tdo, lv_tdo};
    for (int i = 0; i < 8; i++) begin
      inq[i] = 0;
      if (sel[i] && !(single && q.size() > 0)) begin
        q.push_back(i);
        inq[i] = 1;
      end
    end
    e_tck = '0; e_tms = '1; e_tdi = '1; e_trst = '1;
    for (int k = 0; k < q.size(); k++) begin
      e_tck[q[k]]  = m_tck;
      e_tms[q[k]]  = m_tms;
      e_trst[q[k]] = m_trst;
      e_tdi[q[k]]  = (k == 0) ? m_tdi : tdo_all[q[k-1]];
    end
    back = (q.size() == 0) ? m_tdi : tdo_all[q[q.size()-1]];
    g_tck = {hv_tck, lv_tck}; g_tms = {hv_tms, lv_tms};
    g_tdi = {hv_tdi, lv_tdi}; g_trst = {hv_trst_n, lv_trst_n};
    for (int i = 0; i < 8; i++) begin
      if (inq[i]) rq = src_rem ? {pre, "R3 R1"} : {pre, "R3"};
      else if (sel[i]) rq = {pre, "R8"};
      else rq = {pre, "R4"};
      check_bit(rq, $sformatf("chain%0d tck", i), g_tck[i], e_tck[i]);
      check_bit(rq, $sformatf("chain%0d tms", i), g_tms[i], e_tms[i]);
      check_bit(rq, $sformatf("chain%0d trst_n", i), g_trst[i], e_trst[i]);
      check_bit(inq[i] ? {pre, "R5"} : rq, $sformatf("chain%0d tdi", i), g_tdi[i], e_tdi[i]);
    end
    rq = (q.size() == 0) ? {pre, "R7"} : {pre, "R6"};
    check_bit(rq, "active tdo", src_rem ? rem_tdo : hdr_tdo, back);
    check_bit({pre, "R2"}, "idle tdo", src_rem ? hdr_tdo : rem_tdo, 1'b1);
  endtask

  task automatic drive(logic s_rem, logic sgl, logic [7:0] s);
    src_rem = s_rem; single = sgl; sel = s;
    {hdr_tck, hdr_tms, hdr_tdi, hdr_trst_n} = 4'($urandom);
    {rem_tck, rem_tms, rem_tdi, rem_trst_n} = 4'($urandom);
    {hv_tdo, lv_tdo} = 8'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    drive(0, 0, 8'h00);
    {hdr_tck, hdr_tms, hdr_tdi, hdr_trst_n} = 4'b0010;
    @(negedge clk); compare("R7 empty ");
    // directed cases
    @(posedge clk); drive(0, 0, 8'hFF); @(negedge clk); compare("R5 all ");
    @(posedge clk); drive(1, 0, 8'hC0); @(negedge clk); compare("R5 hv ");
    @(posedge clk); drive(0, 1, 8'b0010_1100); @(negedge clk); compare("R8 sparse ");
    @(posedge clk); drive(1, 1, 8'h80); @(negedge clk); compare("R8 top ");
    @(posedge clk); drive(1, 0, 8'h00); @(negedge clk); compare("R7 remote ");
    @(posedge clk); drive(0, 0, 8'h01); @(negedge clk); compare("R6 one ");
    @(posedge clk); drive(1, 0, 8'b1010_0101); @(negedge clk); compare("R1 ");
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk);
      drive(1'($urandom), 1'($urandom), 8'($urandom));
      @(negedge clk);
      compare("");
      // R9: change between edges, check without a clock edge
      if (n % 4 == 0) begin
        drive(1'($urandom), 1'($urandom), 8'($urandom));
        #1 compare("R9 ");
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule